// File: doc/BRIEF.md
# Rotation Factor Generator for a 64-Point Radix-2 FFT

This block supplies the complex rotation factor that a radix-2 FFT butterfly uses to scale its lower input. A butterfly controller presents an index `r` with a valid strobe. One clock later the block returns the cosine term `c` and the sine magnitude term `d` as two signed fixed-point words, so that the factor is `W = c - j*d = exp(-j*2*pi*r/N)`.

The factors are not stored as a full table. A single quarter-wave table holds the cosine values from 0 up to a quarter turn, and both outputs are read from it. For indices past the quarter turn, an address-folding stage mirrors the address and negates the cosine term. For indices in the upper half of the circle, it negates the whole factor. The table is computed while the design elaborates, so no data file is loaded.

Top module: `twf_gen`

## Requirements
- R1: While `rst_n` is low, and on the first clock edge after it rises, `out_valid` is 0 and `out_c` and `out_d` are both 0.
- R2: `out_valid` on a clock edge equals `in_valid` sampled on the previous edge. The outputs for an index accepted on one edge are present from that edge until the next one.
- R3: Outputs are signed 16-bit two's complement with 14 fraction bits, so 1.0 is 16384. Each value is the quarter-table entry T[k] = round(16384*cos(2*pi*k/64)) for k = 0..16, with T[0] = 16384, T[8] = 11585 and T[16] = 0.
- R4: For 6-bit index values r = 0..16: `out_c` = T[r] and `out_d` = T[16-r].
- R5: For r = 17..31: `out_c` = -T[32-r] and `out_d` = T[r-16]. Examples: r=24 gives (-11585, 11585) and r=31 gives (-16305, 1606).
- R6: For r = 32..63 both outputs are the negation of the values for r-32. Examples: r=32 gives (-16384, 0) and r=48 gives (0, -16384).
- R7: A clock edge where `in_valid` is low leaves `out_c` and `out_d` unchanged, whatever `in_idx` holds.
- R8: The magnitude of each output never exceeds 16384.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Index strobe |
| in_idx | input | 6 | Rotation index r, 0..63 |
| out_valid | output | 1 | Output strobe, one clock after `in_valid` |
| out_c | output | 16 | Cosine term c, Q1.14 |
| out_d | output | 16 | Sine magnitude term d, Q1.14 (W = c - j*d) |

## Verification
Every result is due exactly one rising edge after its index is presented. The bench drives `in_idx` and `in_valid` on the falling edge and reads the outputs on the next falling edge, half a period after the capturing edge.

Back-to-back random indices are checked one transaction behind the stimulus. Each expected pair is computed directly from `cos` and `sin` over the full circle, with rounding away from zero.

The hold check drops `in_valid` and presents a different index. It then reads the outputs on the next falling edge and requires them to be unchanged.

// File: rtl/twf_pkg.sv
package twf_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // Rounded quarter-wave table entry: round(2^frac * cos(2*pi*k/n)), k <= n/4
  function automatic int qcos(input int k, input int n, input int frac);
    real ang;
    real scaled;
    ang    = TWO_PI * real'(k) / real'(n);
    scaled = (2.0 ** frac) * $cos(ang);
    return $rtoi($floor(scaled + 0.5));
  endfunction

  // Conditional two's complement negation on a value of any width up to 32
  function automatic logic signed [31:0] cneg(input logic signed [31:0] v, input logic neg);
    return neg ? -v : v;
  endfunction

endpackage

// File: rtl/twf_quarter_rom.sv
module twf_quarter_rom #(
  parameter  int N_PTS = 64,
  parameter  int WID   = 16,
  parameter  int FRAC  = 14,
  localparam int QTR   = N_PTS / 4,
  localparam int AW    = $clog2(QTR + 1)
) (
  input  logic [AW-1:0]          addr,
  output logic signed [WID-1:0]  data
);

  logic signed [WID-1:0] tbl [QTR+1];

  // One constant per quarter-wave point, computed at elaboration
  for (genvar k = 0; k <= QTR; k++) begin : g_entry
    localparam int VAL = twf_pkg::qcos(k, N_PTS, FRAC);
    assign tbl[k] = WID'(VAL);
  end

  assign data = tbl[addr];

  // R3: folded address must stay inside the quarter table
  always_comb begin
    assert_rom_addr_in_range_R3: assert (int'(addr) <= QTR)
      else $error("quarter table address %0d beyond %0d", addr, QTR);
  end

endmodule

// File: rtl/twf_fold.sv
module twf_fold #(
  parameter  int N_PTS = 64,
  localparam int IDXW  = $clog2(N_PTS),
  localparam int QTR   = N_PTS / 4,
  localparam int HALF  = N_PTS / 2,
  localparam int AW    = $clog2(QTR + 1)
) (
  input  logic [IDXW-1:0] idx,
  output logic [AW-1:0]   addr_c,
  output logic [AW-1:0]   addr_d,
  output logic            neg_c,
  output logic            neg_d
);

  logic [IDXW-2:0] low;
  logic            upper_half;
  logic            second_qtr;
  int              low_i;

  assign low        = idx[IDXW-2:0];
  assign upper_half = idx[IDXW-1];
  assign low_i      = int'(low);
  assign second_qtr = (low_i > QTR);

  always_comb begin
    if (second_qtr) begin
      addr_c = AW'(HALF - low_i);
      addr_d = AW'(low_i - QTR);
    end else begin
      addr_c = AW'(low_i);
      addr_d = AW'(QTR - low_i);
    end
    // Periodicity: W(r + N/2) = -W(r) flips both signs
    neg_c = second_qtr ^ upper_half;
    neg_d = upper_half;
  end

  // R4/R5: the two folded addresses always span a quarter turn together
  always_comb begin
    assert_fold_sum_R4: assert (int'(addr_c) + int'(addr_d) == QTR || second_qtr)
      else $error("fold addresses %0d/%0d do not complement", addr_c, addr_d);
  end

endmodule

// File: rtl/twf_gen.sv
module twf_gen #(
  parameter  int N_PTS = 64,
  parameter  int WID   = 16,
  parameter  int FRAC  = 14,
  localparam int IDXW  = $clog2(N_PTS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [IDXW-1:0]        in_idx,
  output logic                   out_valid,
  output logic signed [WID-1:0]  out_c,
  output logic signed [WID-1:0]  out_d
);

  localparam int QTR  = N_PTS / 4;
  localparam int HALF = N_PTS / 2;
  localparam int AW   = $clog2(QTR + 1);
  localparam logic signed [WID-1:0] ONE = WID'(1 << FRAC);

  logic [AW-1:0]         addr_c, addr_d;
  logic                  neg_c, neg_d;
  logic signed [WID-1:0] mag_c, mag_d;
  logic signed [WID-1:0] next_c, next_d;
  logic                  accept;

  twf_fold #(.N_PTS(N_PTS)) u_fold (
    .idx    (in_idx),
    .addr_c (addr_c),
    .addr_d (addr_d),
    .neg_c  (neg_c),
    .neg_d  (neg_d)
  );

  twf_quarter_rom #(.N_PTS(N_PTS), .WID(WID), .FRAC(FRAC)) u_rom_c (
    .addr (addr_c),
    .data (mag_c)
  );

  twf_quarter_rom #(.N_PTS(N_PTS), .WID(WID), .FRAC(FRAC)) u_rom_d (
    .addr (addr_d),
    .data (mag_d)
  );

  assign accept = in_valid;
  assign next_c = WID'(twf_pkg::cneg(32'(mag_c), neg_c));
  assign next_d = WID'(twf_pkg::cneg(32'(mag_d), neg_d));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_c     <= '0;
      out_d     <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_c <= next_c;
        out_d <= next_d;
      end
    end
  end

  // R2: strobe follows the input strobe by one edge
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R7: outputs are held while no index is accepted
  assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_c) && $stable(out_d)));

  // R6: the half-turn index yields exactly -1.0 on the cosine term
  assert_half_turn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && int'(in_idx) == HALF) |=> (out_c == -ONE && out_d == '0));

  // R4: the zero index yields exactly +1.0 on the cosine term
  assert_zero_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_idx == '0) |=> (out_c == ONE && out_d == '0));

  // R8: magnitudes stay inside the Q1.14 unit range
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_c <= ONE && out_c >= -ONE && out_d <= ONE && out_d >= -ONE));

endmodule

// File: tb/twf_gen_tb.sv
module twf_gen_tb;

  localparam int N = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [5:0]        in_idx = '0;
  logic              out_valid;
  logic signed [15:0] out_c, out_d;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  twf_gen u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_idx    (in_idx),
    .out_valid (out_valid),
    .out_c     (out_c),
    .out_d     (out_d)
  );

  // Full-circle reference, rounded half away from zero
  function automatic int rnd(input real x);
    if (x >= 0.0) return $rtoi($floor(x + 0.5));
    return -$rtoi($floor(-x + 0.5));
  endfunction

  function automatic int ref_c(input int r);
    return rnd(16384.0 * $cos(6.283185307179586 * real'(r) / real'(N)));
  endfunction

  function automatic int ref_d(input int r);
    return rnd(16384.0 * $sin(6.283185307179586 * real'(r) / real'(N)));
  endfunction

  function automatic string tag_of(input int r);
    if (r <= 16) return "R4";
    if (r <= 31) return "R5";
    return "R6";
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Checks the values produced for index r (already captured)
  task automatic chk_pair(input int r);
    chk(tag_of(r), $sformatf("c r=%0d", r), int'(out_c), ref_c(r));
    chk(tag_of(r), $sformatf("d r=%0d", r), int'(out_d), ref_d(r));
    chk("R8", $sformatf("range r=%0d", r),
        int'((out_c <= 16384 && out_c >= -16384 && out_d <= 16384 && out_d >= -16384)), 1);
  endtask

  task automatic single(input int r);
    @(negedge clk);
    in_valid = 1'b1;
    in_idx   = 6'(r);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2", "valid after one edge", int'(out_valid), 1);
    chk_pair(r);
  endtask

  initial begin
    int prev;
    bit pv;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", int'(out_valid), 0);
    chk("R1", "c in reset", int'(out_c), 0);
    chk("R1", "d in reset", int'(out_d), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "valid after reset", int'(out_valid), 0);

    // R3 anchors and directed corners
    single(0);
    chk("R3", "T[0]", int'(out_c), 16384);
    single(8);
    chk("R3", "T[8]", int'(out_c), 11585);
    single(16);
    chk("R3", "T[16] as c", int'(out_c), 0);
    single(17);
    single(24);
    chk("R5", "r24 c", int'(out_c), -11585);
    single(31);
    chk("R5", "r31 d", int'(out_d), 1606);
    single(32);
    chk("R6", "r32 c", int'(out_c), -16384);
    single(48);
    chk("R6", "r48 d", int'(out_d), -16384);
    single(63);

    // R7: idle edge with a different index leaves outputs unchanged
    single(5);
    @(negedge clk);
    in_valid = 1'b0;
    in_idx   = 6'd40;
    @(negedge clk);
    chk("R7", "hold c", int'(out_c), ref_c(5));
    chk("R7", "hold d", int'(out_d), ref_d(5));
    chk("R2", "valid low after idle", int'(out_valid), 0);

    // Random back-to-back stream with gaps
    void'($urandom(32'd1234));
    pv = 1'b0;
    prev = 0;
    for (int i = 0; i < 300; i++) begin
      bit v;
      int r;
      v = ($urandom % 4) != 0;
      r = int'($urandom % 64);
      @(negedge clk);
      if (pv) chk_pair(prev);
      chk("R2", "random valid", int'(out_valid), int'(pv));
      in_valid = v;
      in_idx   = 6'(r);
      if (v) prev = r;
      pv = v;
    end
    @(negedge clk);
    in_valid = 1'b0;
    if (pv) chk_pair(prev);

    // Exhaustive sweep of all indices
    for (int r = 0; r < 64; r++) single(r);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule